// File: doc/BRIEF.md
# Shiftable Character Display RAM Scanner

This block stores 80 eight-bit character codes for a single-line character display and continuously scans a window of eight consecutive codes out to a panel driver. Each scanned character appears on `char_o` together with its digit index and a one-cycle transfer strobe. A frame marker flags the strobe that carries digit 0.

The visible window starts at a shift offset inside a circular 80-entry address space. A left-shift command moves the window one position toward higher addresses. A right-shift command moves it one position toward lower addresses. Both wrap across the 0x4F/0x00 boundary.

The storage has a single access port. The scanner owns one read slot in every `SLOT` cycles. A CPU write that lands in a free cycle commits at once. A write that collides with a read slot is parked for one cycle and committed in the next, free cycle, with `busy_o` raised while it waits. As a result, the refresh never sees a half-done write, and a write only changes the digit that shows the written address.

Top module: `char_scan_top`

## Requirements
- R1: After reset every entry holds 0x20, the shift offset is 0, `xfer_o`, `frame_o` and `busy_o` are low, `digit_o` is 0 and `char_o` is 0x20.
- R2: One character is scanned every `SLOT` (default 2) cycles. `xfer_o` is high for exactly one cycle per character, and `digit_o` steps 0,1,...,7,0,... without gaps.
- R3: `frame_o` is high only together with `xfer_o` on digit 0.
- R4: Digit i shows the entry at address (offset + i) mod 80. With offset 0 the digits show 0x00..0x07.
- R5: A one-cycle pulse on `shift_left_i` raises the offset by one, wrapping from 79 to 0, so that one left shift from reset shows 0x01..0x08.
- R6: A one-cycle pulse on `shift_right_i` lowers the offset by one, wrapping from 0 to 79, so that one right shift from reset shows 0x4F,0x00..0x06.
- R7: Shift-left and shift-right asserted in the same cycle leave the offset unchanged.
- R8: A write whose request is sampled in a cycle without a read slot commits at that edge, and `busy_o` stays low.
- R9: A write sampled in a read slot is held and committed one cycle later. `busy_o` is high for exactly that one cycle.
- R10: A write request sampled while `busy_o` is high is dropped.
- R11: Writes to addresses 0x50..0x7F change no entry. In particular, they do not alias onto 0x00..0x2F.
- R12: A write changes only the digit that shows the written address. All other scanned codes stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write request, one cycle |
| wr_addr_i | input | 7 | CPU write address, bit 0 is the LSB |
| wr_data_i | input | 8 | CPU write character code |
| shift_left_i | input | 1 | Move window one position up, one-cycle pulse |
| shift_right_i | input | 1 | Move window one position down, one-cycle pulse |
| busy_o | output | 1 | A write is parked and will commit next cycle |
| char_o | output | 8 | Scanned character code |
| digit_o | output | 3 | Digit index of `char_o` |
| xfer_o | output | 1 | Transfer strobe, one cycle per character |
| frame_o | output | 1 | Strobe carries digit 0 |

## Verification
The bench aims writes precisely at read-slot cycles and at free cycles, and it issues a second write while the first is parked.

Each design fault has a visible effect:
- A design that drops or delays the parked write shows the old code at digit 3.
- A design that accepts the write issued while busy shows the second code at digit 4.

The bench also shifts the window across the wrap boundary in both directions and issues both shift commands at once:
- An offset that does not wrap modulo 80 shows spaces or wrong codes in place of 0x4F.
- A design that lets one of the two simultaneous commands win shifts the whole frame by one.

Writes above 0x4F carry a distinctive code. A design that truncates the address places that code at digit 0.

// File: rtl/char_scan_pkg.sv
package char_scan_pkg;
  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] data;
  } wr_req_t;
endpackage

// File: rtl/char_scan_ram.sv
module char_scan_ram #(
  parameter int DEPTH = 80,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(char_scan_pkg::BLANK_CODE);
    end else if (we_i && (waddr_i < LIMIT)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = DW'(char_scan_pkg::BLANK_CODE);
    if (raddr_i < LIMIT) rdata_o = mem_q[raddr_i];
  end
endmodule

// File: rtl/char_scan_offset.sv
module char_scan_offset #(
  parameter int DEPTH = 80,
  parameter int AW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          left_i,
  input  logic          right_i,
  output logic [AW-1:0] off_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] off_q, off_d;

  always_comb begin
    off_d = off_q;
    unique case ({left_i, right_i})
      2'b10:   off_d = (off_q == TOP) ? '0 : off_q + AW'(1);
      2'b01:   off_d = (off_q == '0) ? TOP : off_q - AW'(1);
      default: off_d = off_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= off_d;
  end

  assign off_o = off_q;
endmodule

// File: rtl/char_scan_seq.sv
module char_scan_seq #(
  parameter int DEPTH  = 80,
  parameter int AW     = 7,
  parameter int DIGITS = 8,
  parameter int SLOT   = 2,
  localparam int DIG_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int PH_W  = (SLOT > 1) ? $clog2(SLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    off_i,
  output logic             rd_slot_o,
  output logic [DIG_W-1:0] digit_o,
  output logic [AW-1:0]    rd_addr_o
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SLOT - 1);
  localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(DIGITS - 1);
  localparam logic [AW:0]      MOD      = (AW+1)'(DEPTH);

  logic [PH_W-1:0]  ph_q;
  logic [DIG_W-1:0] dig_q;
  logic [AW:0]      sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      dig_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
      if (rd_slot_o) dig_q <= (dig_q == DIG_LAST) ? '0 : dig_q + DIG_W'(1);
    end
  end

  // window position wraps modulo DEPTH
  always_comb begin
    sum = {1'b0, off_i} + (AW+1)'(dig_q);
    if (sum >= MOD) sum = sum - MOD;
  end

  assign rd_slot_o = (ph_q == '0);
  assign digit_o   = dig_q;
  assign rd_addr_o = sum[AW-1:0];
endmodule

// File: rtl/char_scan_arb.sv
module char_scan_arb #(
  parameter int DEPTH = 80,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_slot_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  logic          accept;

  // out-of-range and busy-time requests are discarded
  assign accept = wr_en_i && (wr_addr_i < LIMIT) && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= accept && rd_slot_i;
      if (accept && rd_slot_i) begin
        pend_addr_q <= wr_addr_i;
        pend_data_q <= wr_data_i;
      end
    end
  end

  // parked write always lands in a free cycle since SLOT >= 2
  assign we_o    = pend_q || (accept && !rd_slot_i);
  assign waddr_o = pend_q ? pend_addr_q : wr_addr_i;
  assign wdata_o = pend_q ? pend_data_q : wr_data_i;
  assign busy_o  = pend_q;
endmodule

// File: rtl/char_scan_top.sv
module char_scan_top #(
  parameter int DEPTH  = 80,
  parameter int AW     = 7,
  parameter int DW     = 8,
  parameter int DIGITS = 8,
  parameter int SLOT   = 2,
  localparam int DIG_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             shift_left_i,
  input  logic             shift_right_i,
  output logic             busy_o,
  output logic [DW-1:0]    char_o,
  output logic [DIG_W-1:0] digit_o,
  output logic             xfer_o,
  output logic             frame_o
);
  logic [AW-1:0]    off;
  logic             rd_slot;
  logic [DIG_W-1:0] scan_dig;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [DW-1:0]    wdata;

  char_scan_offset #(.DEPTH(DEPTH), .AW(AW)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .left_i(shift_left_i), .right_i(shift_right_i), .off_o(off)
  );

  char_scan_seq #(.DEPTH(DEPTH), .AW(AW), .DIGITS(DIGITS), .SLOT(SLOT)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .off_i(off),
    .rd_slot_o(rd_slot), .digit_o(scan_dig), .rd_addr_o(rd_addr)
  );

  char_scan_arb #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_slot_i(rd_slot),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .busy_o(busy_o)
  );

  char_scan_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o  <= DW'(char_scan_pkg::BLANK_CODE);
      digit_o <= '0;
      xfer_o  <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      xfer_o  <= rd_slot;
      frame_o <= rd_slot && (scan_dig == '0);
      if (rd_slot) begin
        char_o  <= rd_data;
        digit_o <= scan_dig;
      end
    end
  end
endmodule

// File: rtl/char_scan_checker.sv
module char_scan_checker #(
  parameter int DIGITS = 8,
  parameter int DIG_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_o,
  input logic             frame_o,
  input logic             busy_o,
  input logic [DIG_W-1:0] digit_o
);
  logic             seen_q;
  logic [DIG_W-1:0] last_q;
  logic [DIG_W-1:0] next_dig;

  assign next_dig = (last_q == DIG_W'(DIGITS - 1)) ? '0 : last_q + DIG_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (xfer_o) begin
      seen_q <= 1'b1;
      last_q <= digit_o;
    end
  end

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);
  a_r2_digit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && seen_q) |-> (digit_o == next_dig));
  a_r2_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (32'(digit_o) < DIGITS));
  a_r3_frame_digit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (xfer_o && digit_o == '0));
  a_r9_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
endmodule

bind char_scan_top char_scan_checker #(.DIGITS(DIGITS), .DIG_W(DIG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xfer_o(xfer_o), .frame_o(frame_o),
  .busy_o(busy_o), .digit_o(digit_o)
);

// File: tb/char_scan_top_bench.sv
module char_scan_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 80;
  localparam int SLOT  = 2;
  localparam int NDIG  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sh_l = 1'b0;
  logic       sh_r = 1'b0;
  logic       busy;
  logic [7:0] char_v;
  logic [2:0] dig_v;
  logic       xfer;
  logic       frame;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] model [DEPTH];
  int         off_m = 0;

  logic [7:0] exp_char [$];
  int         exp_dig  [$];
  string      cur_tag = "";
  bit         armed = 0;
  bit         synced = 0;
  int         prev_x = -1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  char_scan_top u_char_scan_top (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .shift_left_i(sh_l), .shift_right_i(sh_r),
    .busy_o(busy), .char_o(char_v), .digit_o(dig_v),
    .xfer_o(xfer), .frame_o(frame)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // monitor: pops expected items on each strobe of an armed frame
  always @(negedge clk) begin
    if (rst_n && xfer) begin
      if (armed && !synced && frame) synced = 1;
      if (armed && synced && exp_char.size() > 0) begin
        chk({cur_tag, " char"}, int'(char_v), int'(exp_char.pop_front()));
        chk({cur_tag, " digit R2"}, int'(dig_v), exp_dig.pop_front());
        if (prev_x >= 0) chk("R2 strobe spacing", cyc - prev_x, SLOT);
        if (exp_char.size() == 0) begin
          armed = 0;
          synced = 0;
        end
      end
      prev_x = cyc;
    end
  end

  task automatic expect_frame(input string tag);
    repeat (2) @(negedge clk);
    for (int i = 0; i < NDIG; i++) begin
      exp_char.push_back(model[(off_m + i) % DEPTH]);
      exp_dig.push_back(i);
    end
    cur_tag = tag;
    armed = 1;
    while (armed) @(negedge clk);
  endtask

  task automatic align_free;
    @(negedge clk);
    while (!xfer) @(negedge clk);
  endtask

  task automatic wr_free(input logic [6:0] a, input logic [7:0] d);
    align_free();
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    chk("R8 busy stays low", int'(busy), 0);
    if (a < 7'(DEPTH)) model[a] = d;
  endtask

  task automatic do_shift(input bit l, input bit r);
    @(negedge clk);
    sh_l = l; sh_r = r;
    @(negedge clk);
    sh_l = 0; sh_r = 0;
    if (l && !r) off_m = (off_m + 1) % DEPTH;
    if (r && !l) off_m = (off_m + DEPTH - 1) % DEPTH;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h20;
    repeat (3) @(negedge clk);
    chk("R1 xfer idle", int'(xfer), 0);
    chk("R1 frame idle", int'(frame), 0);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 digit zero", int'(dig_v), 0);
    chk("R1 char blank", int'(char_v), 8'h20);
    rst_n = 1;

    expect_frame("R1 blank frame R3");

    for (int i = 0; i < NDIG; i++) wr_free(7'(i), 8'h41 + 8'(i));
    wr_free(7'h08, 8'h48);
    wr_free(7'h4F, 8'h5A);
    wr_free(7'h4E, 8'h59);
    expect_frame("R4 mapping");

    // write in read slot, then a second request while parked
    align_free();
    @(negedge clk);
    wr_en = 1; wr_addr = 7'h03; wr_data = 8'hC3;
    @(negedge clk);
    chk("R9 busy while parked", int'(busy), 1);
    wr_addr = 7'h04; wr_data = 8'h77;
    @(negedge clk);
    wr_en = 0;
    chk("R9 busy released", int'(busy), 0);
    model[3] = 8'hC3;
    expect_frame("R9 R10 R12 single digit changed");

    wr_free(7'h50, 8'hEE);
    wr_free(7'h7F, 8'hEE);
    wr_free(7'h5A, 8'hEE);
    expect_frame("R11 out of range ignored");

    do_shift(0, 1);
    expect_frame("R6 right shift wrap");
    do_shift(1, 0);
    expect_frame("R5 left wrap to zero");
    do_shift(1, 0);
    expect_frame("R5 left shift");
    do_shift(1, 1);
    expect_frame("R7 both shifts");
    do_shift(0, 1);
    do_shift(0, 1);
    do_shift(0, 1);
    expect_frame("R6 repeated right shift");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule